// File: doc/BRIEF.md
# Tile Broadcast Interconnect

This block joins sixteen processing elements, arranged as four clusters of four, into one tile. Inside a cluster the four elements share a byte-wide bus. Any element can put a byte on it, and every element of that cluster sees the byte one cycle later, along with the index of the element that sent it. Across clusters, each element owns a private four-bit lane. The four lanes of a cluster together form that cluster's sixteen-bit outgoing bus. Whatever an element places on its lane is registered once and then presented to every other cluster in the tile, but never to its own cluster.

The schedule of who sends when is fixed when the application is mapped. For that reason the block holds no routers, queues or arbiters, only selection, valid flags and one register stage per level. A receiver latches a slot in the cycle its valid flag is high. Between transfers, each slot keeps its last data.

Top module: `tile_bus`

## Requirements
- R1: While `rst` is high at a rising edge, every valid output is cleared, and every data and source-index output is cleared to zero.
- R2: When exactly one element `e` of cluster `c` (drive-enable bit `c*4+e`) asserts its drive-enable, then after the next rising edge `ibus_valid[c]` is 1. In that cycle `ibus_data[c*8 +: 8]` equals that element's byte and `ibus_src[c*2 +: 2]` equals `e`.
- R3: After a cycle in which no element of cluster `c` drives, `ibus_valid[c]` is 0 and cluster `c`'s byte and source index keep their previous values.
- R4: The four intra-cluster buses are independent. Drivers in different clusters in the same cycle are each delivered to their own cluster.
- R5: At most one element per cluster drives in a cycle. A second simultaneous driver is a schedule error that an assertion reports; no arbitration is performed.
- R6: When lane `e` of source cluster `s` (enable bit `s*4+e`, nibble `s*16+e*4`) is enabled, then after the next rising edge every other cluster `d` sees it as valid at slot `(d*4+s)*4+e` of `xbus_valid`. The nibble appears at bit `((d*4+s)*4+e)*4` of `xbus_data`.
- R7: A cluster never receives its own cluster's lanes. Slots with `d == s` always have valid 0 and data 0.
- R8: The four lanes of a cluster are independent and may all fire in one cycle. A lane that is not enabled reads valid 0 at every destination and keeps its previous nibble.
- R9: Delivery takes exactly one registered cycle at each level. Outputs do not change between a change of the inputs and the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ibus_drv_en | input | 16 | Per-element drive-enable for its cluster's byte bus, bit `c*4+e` |
| ibus_drv_data | input | 128 | Per-element byte, element `c*4+e` at bit `(c*4+e)*8` |
| ibus_valid | output | 4 | Per-cluster byte-bus valid flag |
| ibus_data | output | 32 | Per-cluster delivered byte |
| ibus_src | output | 8 | Per-cluster index of the sending element, two bits each |
| xbus_lane_en | input | 16 | Per-element enable for its outgoing lane |
| xbus_lane_data | input | 64 | Per-element outgoing nibble |
| xbus_valid | output | 64 | Valid per destination, source cluster and lane, slot `(d*4+s)*4+e` |
| xbus_data | output | 256 | Nibble per destination, source cluster and lane |

## Verification
The hardest situation to bring about is a cycle in which all four clusters use their byte buses and all sixteen lanes fire together. That is the only case where a mistake in slot indexing or a leak into a cluster's own view shows up as a wrong value rather than a missing one. The stimulus table contains diagonal and anti-diagonal driver patterns, full and checkerboard lane masks, and each element's byte and nibble depend on its own index. The tables are interleaved with idle rows, so hold behaviour is observed right after traffic.

// File: rtl/tilebus_pkg.sv
package tilebus_pkg;
    localparam int N_CL    = 4;
    localparam int N_EL    = 4;
    localparam int INTRA_W = 8;
    localparam int LANE_W  = 4;

    // Flat slot position of (destination, source, lane) in the broadcast view.
    function automatic int xslot(input int d, input int s, input int e,
                                 input int ncl, input int nel);
        return (d * ncl + s) * nel + e;
    endfunction
endpackage

// File: rtl/intra_bus.sv
module intra_bus #(
    parameter int N_EL   = tilebus_pkg::N_EL,
    parameter int DATA_W = tilebus_pkg::INTRA_W,
    localparam int SRC_W = (N_EL > 1) ? $clog2(N_EL) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_EL-1:0]          drv_en,
    input  logic [N_EL*DATA_W-1:0]   drv_data,
    output logic                     rx_valid,
    output logic [DATA_W-1:0]        rx_data,
    output logic [SRC_W-1:0]         rx_src
);
    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t nxt, cur;

    // Static schedule: at most one driver, so an OR-mux suffices.
    always_comb begin
        nxt = '0;
        for (int i = 0; i < N_EL; i++) begin
            if (drv_en[i]) begin
                nxt.valid = 1'b1;
                nxt.src   = nxt.src | SRC_W'(i);
                nxt.data  = nxt.data | drv_data[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur.valid <= nxt.valid;
            if (nxt.valid) begin
                cur.src  <= nxt.src;
                cur.data <= nxt.data;
            end
        end
    end

    assign rx_valid = cur.valid;
    assign rx_data  = cur.data;
    assign rx_src   = cur.src;

    p_one_driver_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_en));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (drv_en == '0) |=> (!rx_valid && $stable(rx_data) && $stable(rx_src)));

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (drv_en != '0) |=> rx_valid);

    for (genvar i = 0; i < N_EL; i++) begin : g_src_chk
        p_src_r2: assert property (@(posedge clk) disable iff (rst)
            (drv_en == (N_EL'(1) << i)) |=>
            (rx_src == SRC_W'(i) && rx_data == $past(drv_data[i*DATA_W +: DATA_W])));
    end
endmodule

// File: rtl/lane_reg.sv
module lane_reg #(
    parameter int N_EL   = tilebus_pkg::N_EL,
    parameter int LANE_W = tilebus_pkg::LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_EL-1:0]         lane_en,
    input  logic [N_EL*LANE_W-1:0]  lane_data,
    output logic [N_EL-1:0]         q_valid,
    output logic [N_EL*LANE_W-1:0]  q_data
);
    for (genvar e = 0; e < N_EL; e++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q_valid[e]                  <= 1'b0;
                q_data[e*LANE_W +: LANE_W]  <= '0;
            end else begin
                q_valid[e] <= lane_en[e];
                if (lane_en[e])
                    q_data[e*LANE_W +: LANE_W] <= lane_data[e*LANE_W +: LANE_W];
            end
        end

        p_lane_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !lane_en[e] |=> (!q_valid[e] && $stable(q_data[e*LANE_W +: LANE_W])));
    end
endmodule

// File: rtl/tile_bus.sv
module tile_bus #(
    parameter int N_CL    = tilebus_pkg::N_CL,
    parameter int N_EL    = tilebus_pkg::N_EL,
    parameter int INTRA_W = tilebus_pkg::INTRA_W,
    parameter int LANE_W  = tilebus_pkg::LANE_W,
    localparam int N_PE   = N_CL * N_EL,
    localparam int SRC_W  = (N_EL > 1) ? $clog2(N_EL) : 1,
    localparam int N_SLOT = N_CL * N_CL * N_EL
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PE-1:0]           ibus_drv_en,
    input  logic [N_PE*INTRA_W-1:0]   ibus_drv_data,
    output logic [N_CL-1:0]           ibus_valid,
    output logic [N_CL*INTRA_W-1:0]   ibus_data,
    output logic [N_CL*SRC_W-1:0]     ibus_src,
    input  logic [N_PE-1:0]           xbus_lane_en,
    input  logic [N_PE*LANE_W-1:0]    xbus_lane_data,
    output logic [N_SLOT-1:0]         xbus_valid,
    output logic [N_SLOT*LANE_W-1:0]  xbus_data
);
    import tilebus_pkg::xslot;

    logic [N_CL*N_EL-1:0]        src_valid;
    logic [N_CL*N_EL*LANE_W-1:0] src_data;

    for (genvar c = 0; c < N_CL; c++) begin : g_cluster
        intra_bus #(.N_EL(N_EL), .DATA_W(INTRA_W)) u_intra (
            .clk      (clk),
            .rst      (rst),
            .drv_en   (ibus_drv_en[c*N_EL +: N_EL]),
            .drv_data (ibus_drv_data[c*N_EL*INTRA_W +: N_EL*INTRA_W]),
            .rx_valid (ibus_valid[c]),
            .rx_data  (ibus_data[c*INTRA_W +: INTRA_W]),
            .rx_src   (ibus_src[c*SRC_W +: SRC_W])
        );

        lane_reg #(.N_EL(N_EL), .LANE_W(LANE_W)) u_lanes (
            .clk       (clk),
            .rst       (rst),
            .lane_en   (xbus_lane_en[c*N_EL +: N_EL]),
            .lane_data (xbus_lane_data[c*N_EL*LANE_W +: N_EL*LANE_W]),
            .q_valid   (src_valid[c*N_EL +: N_EL]),
            .q_data    (src_data[c*N_EL*LANE_W +: N_EL*LANE_W])
        );
    end

    // Broadcast fan-out: every destination sees every other cluster's lanes.
    for (genvar d = 0; d < N_CL; d++) begin : g_dst
        for (genvar s = 0; s < N_CL; s++) begin : g_src
            for (genvar e = 0; e < N_EL; e++) begin : g_ln
                localparam int K = xslot(d, s, e, N_CL, N_EL);
                if (d == s) begin : g_self
                    assign xbus_valid[K]                 = 1'b0;
                    assign xbus_data[K*LANE_W +: LANE_W] = '0;
                end else begin : g_peer
                    assign xbus_valid[K]                 = src_valid[s*N_EL + e];
                    assign xbus_data[K*LANE_W +: LANE_W] = src_data[(s*N_EL + e)*LANE_W +: LANE_W];

                    p_bcast_r6: assert property (@(posedge clk) disable iff (rst)
                        xbus_lane_en[s*N_EL + e] |=>
                        (xbus_valid[K] &&
                         xbus_data[K*LANE_W +: LANE_W] ==
                             $past(xbus_lane_data[(s*N_EL + e)*LANE_W +: LANE_W])));
                end
            end
        end
    end
endmodule

// File: tb/tile_bus_tb.sv
`timescale 1ns/1ps
module tile_bus_tb;
    import tilebus_pkg::*;

    localparam int NPE = N_CL * N_EL;
    localparam int NV  = 8;
    localparam logic [15:0] IEN_TAB [NV] = '{16'h0001, 16'h0000, 16'h8421, 16'h1248,
                                            16'h0000, 16'h4000, 16'h0020, 16'h2002};
    localparam logic [15:0] OEN_TAB [NV] = '{16'h0001, 16'h0000, 16'hFFFF, 16'h00F0,
                                            16'hA5A5, 16'h0000, 16'h8000, 16'h0F0F};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPE-1:0]                ien = '0;
    logic [NPE*INTRA_W-1:0]        idat = '0;
    logic [N_CL-1:0]               ivld;
    logic [N_CL*INTRA_W-1:0]       iout;
    logic [N_CL*2-1:0]             isrc;
    logic [NPE-1:0]                oen = '0;
    logic [NPE*LANE_W-1:0]         odat = '0;
    logic [N_CL*N_CL*N_EL-1:0]     xvld;
    logic [N_CL*N_CL*N_EL*LANE_W-1:0] xout;

    always #2.5 clk = ~clk;

    tile_bus u_dut (
        .clk(clk), .rst(rst),
        .ibus_drv_en(ien), .ibus_drv_data(idat),
        .ibus_valid(ivld), .ibus_data(iout), .ibus_src(isrc),
        .xbus_lane_en(oen), .xbus_lane_data(odat),
        .xbus_valid(xvld), .xbus_data(xout)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit multi = 1'b0;

    logic       m_iv [N_CL];
    logic [7:0] m_id [N_CL];
    logic [1:0] m_is [N_CL];
    logic       m_ov [N_CL][N_EL];
    logic [3:0] m_od [N_CL][N_EL];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [7:0] byte_for(input int k, input int i);
        return 8'((i * 17 + k * 29 + 3) & 255);
    endfunction

    function automatic logic [3:0] nib_for(input int k, input int i);
        return 4'((i + 3 * k + 1) & 15);
    endfunction

    task automatic drive(input logic [15:0] ie, input logic [15:0] oe, input int k);
        ien = ie;
        oen = oe;
        for (int i = 0; i < NPE; i++) begin
            idat[i*8 +: 8] = byte_for(k, i);
            odat[i*4 +: 4] = nib_for(k, i);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < N_CL; c++) begin
            m_iv[c] = 1'b0; m_id[c] = '0; m_is[c] = '0;
            for (int e = 0; e < N_EL; e++) begin
                m_ov[c][e] = 1'b0; m_od[c][e] = '0;
            end
        end
    endtask

    // Apply one rising edge worth of the rules R2, R3, R6, R8 to the inputs now driven.
    task automatic model_step();
        int busy = 0;
        for (int c = 0; c < N_CL; c++) begin
            m_iv[c] = 1'b0;
            for (int e = 0; e < N_EL; e++) begin
                if (ien[c*4+e]) begin
                    m_iv[c] = 1'b1;
                    m_id[c] = idat[(c*4+e)*8 +: 8];
                    m_is[c] = 2'(e);
                end
                m_ov[c][e] = oen[c*4+e];
                if (oen[c*4+e]) m_od[c][e] = odat[(c*4+e)*4 +: 4];
            end
            if (m_iv[c]) busy++;
        end
        multi = (busy > 1);
    endtask

    task automatic check_all(input string force_tag);
        string t;
        for (int c = 0; c < N_CL; c++) begin
            if (force_tag != "") t = force_tag;
            else if (m_iv[c]) t = multi ? "R2 R4 R5" : "R2";
            else t = "R3";
            chk($sformatf("%s intra c%0d", t, c),
                64'({ivld[c], isrc[c*2 +: 2], iout[c*8 +: 8]}),
                64'({m_iv[c], m_is[c], m_id[c]}));
        end
        for (int d = 0; d < N_CL; d++) begin
            for (int s = 0; s < N_CL; s++) begin
                logic [19:0] act, exp;
                act = '0; exp = '0;
                for (int e = 0; e < N_EL; e++) begin
                    int k = (d * N_CL + s) * N_EL + e;
                    act[e*5 +: 5] = {xvld[k], xout[k*4 +: 4]};
                    exp[e*5 +: 5] = (d == s) ? 5'b0 : {m_ov[s][e], m_od[s][e]};
                end
                if (force_tag != "") t = force_tag;
                else if (d == s) t = "R7";
                else t = "R6 R8";
                chk($sformatf("%s inter d%0d s%0d", t, d, s), 64'(act), 64'(exp));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;

        // Table walk: drive row k at a falling edge, check it one falling edge later.
        drive(IEN_TAB[0], OEN_TAB[0], 0);
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            model_step();
            check_all("");
            if (k < NV - 1) drive(IEN_TAB[k+1], OEN_TAB[k+1], k + 1);
            else drive('0, '0, 0);
        end

        // Idle after traffic: everything holds (R3, R8).
        @(negedge clk);
        model_step();
        check_all("");

        // R9: no change before the edge, full update after it.
        drive(16'h0010, 16'h0100, 11);
        #1;
        check_all("R9");
        @(negedge clk);
        model_step();
        check_all("R9");

        // All sixteen lanes and all four clusters at once (R4, R5, R8).
        drive(16'h8421, 16'hFFFF, 13);
        @(negedge clk);
        model_step();
        check_all("");
        drive('0, '0, 0);

        // Reset in mid-run clears all state (R1).
        rst = 1'b1;
        @(negedge clk);
        model_reset();
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        model_step();
        check_all("R1");

        finish_run();
    end
endmodule